// File: doc/BRIEF.md
# Four-Stage Pipeline Hazard Controller

This block is the control section of an in-order pipeline with four stages: fetch, decode, execute and writeback. It owns the fetch address and the decode, execute and writeback stage registers that carry each instruction's descriptor. Each descriptor holds a valid bit, two source registers, a destination register and a branch flag. Every cycle the block receives the descriptor fetched at the current address. For the instruction in execute it also receives the resolved branch outcome and target. From these inputs it drives the fetch redirect, the decode stall, the bubble into decode, and the operand bypass selects used by the ALU inputs.

Branches follow a predict-not-taken policy with fixed recovery costs. When a branch reaches decode, the instruction fetched behind it is held in fetch and decode receives a bubble. If the branch resolves not-taken in execute, the held instruction proceeds, so one cycle is lost. If it resolves taken, the held instruction is discarded and fetch restarts at the target, so two cycles are lost. Data dependencies between neighbouring instructions never stall the pipeline. Results are bypassed to the ALU from the writeback-stage register or from the most recently retired result.

Top module: `hzd_pipe_ctl`

## Requirements
- R1: While reset is asserted (synchronous, active low), fetch_pc is 0, ex_valid and wb_valid are 0, dec_stall, redirect and id_bubble are 0, and both bypass selects are 0.
- R2: With no branch in decode or execute, fetch_pc rises by exactly one per cycle. A straight-line run of n instructions starting at address 0 retires its last instruction in cycle n+3, counting the first cycle after reset release as cycle 1.
- R3: In any cycle where decode holds a valid branch, dec_stall is 1. In the next cycle fetch_pc is unchanged and decode holds no valid instruction.
- R4: A branch that resolves not-taken in execute lets the held instruction enter decode in the next cycle, adding exactly one cycle to the run.
- R5: A branch that resolves taken in execute raises redirect in that cycle. In the next cycle fetch_pc equals the target, the instruction that was in fetch never retires, and the run grows by exactly two cycles.
- R6: Bypass select encoding for each ALU operand of the instruction in execute: 0 means register file, 1 means the writeback-stage register, 2 means the last retired result. The select is 1 when the valid instruction now in writeback writes that source register. It is 2 when only the valid instruction that was in writeback one cycle earlier writes it.
- R7: When both the writeback-stage instruction and the previously retired instruction write the same source register, the select is 1 (youngest producer wins).
- R8: A source register numbered 0 always gets select 0, even when a producer names register 0 as its destination.
- R9: Bubbles and discarded instructions never retire and never serve as bypass sources.
- R10: A valid instruction in decode is in execute one cycle later, and a valid instruction in execute is in writeback one cycle later; neither stage ever holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_valid | input | 1 | Fetched descriptor is a real instruction |
| if_is_br | input | 1 | Fetched instruction is a conditional branch |
| if_rs1 | input | REG_W | Fetched first source register |
| if_rs2 | input | REG_W | Fetched second source register |
| if_rd | input | REG_W | Fetched destination register (0 = no write) |
| ex_taken | input | 1 | Branch outcome for the instruction in execute |
| ex_target | input | PC_W | Branch target for the instruction in execute |
| fetch_pc | output | PC_W | Current fetch address |
| redirect | output | 1 | Taken branch in execute; fetch restarts at the target |
| dec_stall | output | 1 | Branch in decode; fetch holds |
| id_bubble | output | 1 | Decode receives a bubble at the next edge |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_pc | output | PC_W | Address of the instruction in execute |
| ex_is_br | output | 1 | Instruction in execute is a branch |
| fwd_a_sel | output | 2 | Bypass select for ALU operand A (first source) |
| fwd_b_sel | output | 2 | Bypass select for ALU operand B (second source) |
| wb_valid | output | 1 | Writeback stage holds an instruction |
| wb_pc | output | PC_W | Address of the instruction in writeback |
| wb_rd | output | REG_W | Destination register of the instruction in writeback |

## Verification
The assertions assume that ex_taken and ex_target are meaningful only while execute holds a valid branch. They also assume the fetched descriptor is a pure function of fetch_pc, so a held fetch presents the same instruction again. The bench models instruction memory as a table indexed by fetch_pc and looks up branch outcomes by ex_pc, which keeps both assumptions true by design. Its programs use only forward-taken branches, so every run terminates. The programs vary producer distance, register 0, doubled producers, and back-to-back branches of both outcomes. Cycle totals are checked against the ideal count plus the fixed branch penalties.

// File: rtl/hzd_pkg.sv
// Package: shared encodings for the pipeline hazard controller.
// Assumes: a two-bit bypass select per ALU operand.
package hzd_pkg;

    localparam int FWD_W = 2;

    // Bypass source for one ALU operand of the instruction in execute.
    typedef enum logic [FWD_W-1:0] {
        FWD_RF  = 2'd0,   // value read from the register file in decode
        FWD_WB  = 2'd1,   // result held in the writeback-stage register
        FWD_RET = 2'd2    // result retired in the previous cycle
    } fwd_src_e;

endpackage

// File: rtl/hzd_fetch_ctl.sv
// Module: hzd_fetch_ctl
// Holds the fetch address. Advances it by one, holds it during a decode
// stall, or loads the branch target on a redirect.
// Assumes: redirect and hold never assert together.
module hzd_fetch_ctl #(
    parameter int PC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic            hold,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);

    // Fetch address register: redirect first, then hold, else sequential.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (redirect) begin
            pc <= target;
        end else if (!hold) begin
            pc <= pc + PC_W'(1);
        end
    end

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !hold) |=> (pc == $past(pc) + PC_W'(1)));

endmodule

// File: rtl/hzd_branch_ctl.sv
// Module: hzd_branch_ctl
// Predict-not-taken control. A branch in decode stalls fetch and sends a
// bubble into decode. A taken branch in execute redirects fetch and
// discards the held fetch slot.
// Assumes: ex_taken is meaningful only while execute holds a valid branch.
module hzd_branch_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic id_valid,
    input  logic id_is_br,
    input  logic ex_valid,
    input  logic ex_is_br,
    input  logic ex_taken,
    output logic dec_stall,
    output logic redirect,
    output logic id_bubble
);

    // Stall and redirect decisions from the decode and execute stages.
    always_comb begin
        dec_stall = id_valid && id_is_br;
        redirect  = ex_valid && ex_is_br && ex_taken;
        id_bubble = dec_stall || redirect;
    end

    // R3: the bubble behind a decoded branch keeps decode empty while it executes
    // R3
    stall_redirect_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_stall && redirect));

endmodule

// File: rtl/hzd_fwd_unit.sv
// Module: hzd_fwd_unit
// Bypass select generation. Compares each decode-stage source with the
// execute-stage and writeback-stage destinations, then registers the
// select so it applies when the consumer reaches execute.
// Assumes: the decode stage never holds, so decode moves into execute each cycle.
module hzd_fwd_unit
    import hzd_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        id_valid,
    input  logic [NSRC-1:0][REG_W-1:0]  id_src,
    input  logic                        ex_valid,
    input  logic [REG_W-1:0]            ex_rd,
    input  logic                        wb_valid,
    input  logic [REG_W-1:0]            wb_rd,
    output logic [NSRC-1:0][FWD_W-1:0]  sel
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic src_live;
        logic hit_ex;
        logic hit_wb;

        // Match terms: a non-zero source against the valid producers ahead.
        always_comb begin
            src_live = id_valid && (id_src[g] != '0);
            hit_ex   = src_live && ex_valid && (ex_rd == id_src[g]);
            hit_wb   = src_live && wb_valid && (wb_rd == id_src[g]);
        end

        // Select register: the younger (execute-stage) producer takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel[g] <= FWD_RF;
            end else if (hit_ex) begin
                sel[g] <= FWD_WB;
            end else if (hit_wb) begin
                sel[g] <= FWD_RET;
            end else begin
                sel[g] <= FWD_RF;
            end
        end

        // R9
        bubble_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !id_valid |=> (sel[g] == FWD_RF));
    end

endmodule

// File: rtl/hzd_pipe_ctl.sv
// Module: hzd_pipe_ctl (top)
// Hazard controller for an in-order fetch/decode/execute/writeback pipeline.
// Holds the per-stage descriptors and wires together fetch, branch and
// bypass control.
// Assumes: the fetched descriptor depends only on fetch_pc. ex_taken and
// ex_target are valid whenever execute holds a valid branch.
module hzd_pipe_ctl
    import hzd_pkg::*;
#(
    parameter int PC_W  = 8,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             if_valid,
    input  logic             if_is_br,
    input  logic [REG_W-1:0] if_rs1,
    input  logic [REG_W-1:0] if_rs2,
    input  logic [REG_W-1:0] if_rd,
    input  logic             ex_taken,
    input  logic [PC_W-1:0]  ex_target,
    output logic [PC_W-1:0]  fetch_pc,
    output logic             redirect,
    output logic             dec_stall,
    output logic             id_bubble,
    output logic             ex_valid,
    output logic [PC_W-1:0]  ex_pc,
    output logic             ex_is_br,
    output logic [1:0]       fwd_a_sel,
    output logic [1:0]       fwd_b_sel,
    output logic             wb_valid,
    output logic [PC_W-1:0]  wb_pc,
    output logic [REG_W-1:0] wb_rd
);

    localparam int NSRC = 2;

    // Decode-stage descriptor.
    logic             id_valid;
    logic [PC_W-1:0]  id_pc;
    logic             id_is_br;
    logic [REG_W-1:0] id_rs1;
    logic [REG_W-1:0] id_rs2;
    logic [REG_W-1:0] id_rd;

    // Execute-stage descriptor beyond the outputs.
    logic [REG_W-1:0] ex_rs1;
    logic [REG_W-1:0] ex_rs2;
    logic [REG_W-1:0] ex_rd;

    logic [NSRC-1:0][REG_W-1:0] id_src;
    logic [NSRC-1:0][FWD_W-1:0] fwd_sel;

    hzd_fetch_ctl #(.PC_W(PC_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .redirect (redirect),
        .hold     (dec_stall),
        .target   (ex_target),
        .pc       (fetch_pc)
    );

    hzd_branch_ctl u_branch (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_valid  (id_valid),
        .id_is_br  (id_is_br),
        .ex_valid  (ex_valid),
        .ex_is_br  (ex_is_br),
        .ex_taken  (ex_taken),
        .dec_stall (dec_stall),
        .redirect  (redirect),
        .id_bubble (id_bubble)
    );

    // Source list for the bypass unit: index 0 feeds operand A.
    always_comb begin
        id_src[0] = id_rs1;
        id_src[1] = id_rs2;
    end

    hzd_fwd_unit #(.REG_W(REG_W), .NSRC(NSRC)) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_valid (id_valid),
        .id_src   (id_src),
        .ex_valid (ex_valid),
        .ex_rd    (ex_rd),
        .wb_valid (wb_valid),
        .wb_rd    (wb_rd),
        .sel      (fwd_sel)
    );

    // Expose the per-operand selects.
    always_comb begin
        fwd_a_sel = fwd_sel[0];
        fwd_b_sel = fwd_sel[1];
    end

    // Decode register: capture the fetched slot unless a bubble is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_valid <= 1'b0;
            id_pc    <= '0;
            id_is_br <= 1'b0;
            id_rs1   <= '0;
            id_rs2   <= '0;
            id_rd    <= '0;
        end else begin
            id_valid <= if_valid && !id_bubble;
            id_pc    <= fetch_pc;
            id_is_br <= if_is_br;
            id_rs1   <= if_rs1;
            id_rs2   <= if_rs2;
            id_rd    <= if_rd;
        end
    end

    // Execute register: decode always advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_valid <= 1'b0;
            ex_pc    <= '0;
            ex_is_br <= 1'b0;
            ex_rs1   <= '0;
            ex_rs2   <= '0;
            ex_rd    <= '0;
        end else begin
            ex_valid <= id_valid;
            ex_pc    <= id_pc;
            ex_is_br <= id_is_br;
            ex_rs1   <= id_rs1;
            ex_rs2   <= id_rs2;
            ex_rd    <= id_rd;
        end
    end

    // Writeback register: execute always advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_pc    <= '0;
            wb_rd    <= '0;
        end else begin
            wb_valid <= ex_valid;
            wb_pc    <= ex_pc;
            wb_rd    <= ex_rd;
        end
    end

    // R10
    id_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> (ex_valid && ex_pc == $past(id_pc)));

    // R10
    ex_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |=> (wb_valid && wb_pc == $past(ex_pc)));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall |=> (!id_valid && fetch_pc == $past(fetch_pc)));

    // R5
    redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (!id_valid && fetch_pc == $past(ex_target)));

    // R4
    nt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_is_br && !ex_taken) |=> (id_valid == $past(if_valid)));

    // R6
    fwd_a_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel == FWD_WB) |-> (wb_valid && wb_rd == ex_rs1));

    // R6
    fwd_b_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_b_sel == FWD_WB) |-> (wb_valid && wb_rd == ex_rs2));

    // R8
    r0_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex_rs1 == '0) |-> (fwd_a_sel == FWD_RF)) and
        ((ex_rs2 == '0) |-> (fwd_b_sel == FWD_RF)));

endmodule

// File: tb/hzd_pipe_ctl_bench.sv
// Directed bench: instruction memory and branch outcomes come from tables.
module hzd_pipe_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W  = 8;
    localparam int REG_W = 5;
    localparam int DEPTH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             if_valid;
    logic             if_is_br;
    logic [REG_W-1:0] if_rs1, if_rs2, if_rd;
    logic             ex_taken;
    logic [PC_W-1:0]  ex_target;
    logic [PC_W-1:0]  fetch_pc;
    logic             redirect, dec_stall, id_bubble;
    logic             ex_valid, ex_is_br, wb_valid;
    logic [PC_W-1:0]  ex_pc, wb_pc;
    logic [1:0]       fwd_a_sel, fwd_b_sel;
    logic [REG_W-1:0] wb_rd;

    // Program tables.
    int               n_prog;
    logic             p_br  [DEPTH];
    logic             p_tk  [DEPTH];
    logic [PC_W-1:0]  p_tgt [DEPTH];
    logic [REG_W-1:0] p_rd  [DEPTH];
    logic [REG_W-1:0] p_rs1 [DEPTH];
    logic [REG_W-1:0] p_rs2 [DEPTH];
    int               exp_path [DEPTH];

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  all_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Instruction memory: descriptor is a pure function of fetch_pc.
    always_comb begin
        if_valid = (int'(fetch_pc) < n_prog);
        if_is_br = if_valid ? p_br[fetch_pc[3:0]]  : 1'b0;
        if_rs1   = if_valid ? p_rs1[fetch_pc[3:0]] : '0;
        if_rs2   = if_valid ? p_rs2[fetch_pc[3:0]] : '0;
        if_rd    = if_valid ? p_rd[fetch_pc[3:0]]  : '0;
        ex_taken  = p_tk[ex_pc[3:0]];
        ex_target = p_tgt[ex_pc[3:0]];
    end

    hzd_pipe_ctl #(.PC_W(PC_W), .REG_W(REG_W)) u_hzd_pipe_ctl (
        .clk(clk), .rst_n(rst_n),
        .if_valid(if_valid), .if_is_br(if_is_br),
        .if_rs1(if_rs1), .if_rs2(if_rs2), .if_rd(if_rd),
        .ex_taken(ex_taken), .ex_target(ex_target),
        .fetch_pc(fetch_pc), .redirect(redirect), .dec_stall(dec_stall),
        .id_bubble(id_bubble), .ex_valid(ex_valid), .ex_pc(ex_pc),
        .ex_is_br(ex_is_br), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .wb_valid(wb_valid), .wb_pc(wb_pc), .wb_rd(wb_rd)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < DEPTH; i++) begin
            p_br[i] = 1'b0; p_tk[i] = 1'b0; p_tgt[i] = '0;
            p_rd[i] = '0; p_rs1[i] = '0; p_rs2[i] = '0; exp_path[i] = 0;
        end
        n_prog = 0;
    endtask

    task automatic put_alu(input int a, input int rd, input int rs1, input int rs2);
        p_br[a] = 1'b0; p_rd[a] = REG_W'(rd);
        p_rs1[a] = REG_W'(rs1); p_rs2[a] = REG_W'(rs2);
    endtask

    task automatic put_br(input int a, input int rs1, input bit tk, input int tgt);
        p_br[a] = 1'b1; p_tk[a] = tk; p_tgt[a] = PC_W'(tgt);
        p_rd[a] = '0; p_rs1[a] = REG_W'(rs1); p_rs2[a] = '0;
    endtask

    // Reference bypass select from the requirement (R6, R7, R8).
    function automatic int exp_sel(input logic [REG_W-1:0] rs, input bit wv,
                                   input logic [REG_W-1:0] wrd, input bit pv,
                                   input logic [REG_W-1:0] prd);
        if (rs == '0) return 0;
        if (wv && wrd == rs) return 1;
        if (pv && prd == rs) return 2;
        return 0;
    endfunction

    // Runs the loaded program from reset and checks timing, order and bypass.
    task automatic run_prog(input string tag, input int exp_len,
                            input int n_br, input int n_tk, input int exp_cycles);
        int cyc = 0, ret = 0, stalls = 0, redirs = 0;
        bit fin = 1'b0, chk_hold = 1'b0, chk_tgt = 1'b0;
        bit pv = 1'b0;
        logic [REG_W-1:0] prd = '0;
        logic [PC_W-1:0] hold_pc = '0, tgt_pc = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        while (!fin && cyc < 200) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (chk_hold) check({tag, " R3 fetch held"}, int'(fetch_pc), int'(hold_pc));
            if (chk_tgt)  check({tag, " R5 fetch at target"}, int'(fetch_pc), int'(tgt_pc));
            chk_hold = 1'b0; chk_tgt = 1'b0;
            if (dec_stall) begin stalls++; chk_hold = 1'b1; hold_pc = fetch_pc; end
            if (redirect)  begin redirs++; chk_tgt = 1'b1; tgt_pc = ex_target; end
            if (ex_valid) begin
                check({tag, " R6/R7/R8 operand A select"}, int'(fwd_a_sel),
                      exp_sel(p_rs1[ex_pc[3:0]], wb_valid, p_rd[wb_pc[3:0]], pv, prd));
                check({tag, " R6/R7/R8 operand B select"}, int'(fwd_b_sel),
                      exp_sel(p_rs2[ex_pc[3:0]], wb_valid, p_rd[wb_pc[3:0]], pv, prd));
            end
            if (wb_valid) begin
                // R9: only the expected dynamic path retires, in order
                check({tag, " R9 retire order"}, int'(wb_pc),
                      (ret < exp_len) ? exp_path[ret] : -1);
                ret++;
                if (ret == exp_len) fin = 1'b1;
            end
            pv  = wb_valid;
            prd = p_rd[wb_pc[3:0]];
        end
        check({tag, " R2/R4/R5 total cycles"}, cyc + 1, exp_cycles);
        check({tag, " R3 stall count"}, stalls, n_br);
        check({tag, " R5 redirect count"}, redirs, n_tk);
    endtask

    // R1: reset state.
    task automatic t_reset();
        clear_prog();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 fetch_pc", int'(fetch_pc), 0);
        check("R1 ex_valid", int'(ex_valid), 0);
        check("R1 wb_valid", int'(wb_valid), 0);
        check("R1 dec_stall/redirect/id_bubble", int'({dec_stall, redirect, id_bubble}), 0);
        check("R1 bypass selects", int'({fwd_a_sel, fwd_b_sel}), 0);
    endtask

    // R2, R6, R7, R8: straight line with dependencies at several distances.
    task automatic t_straight();
        clear_prog();
        put_alu(0, 1, 0, 0);
        put_alu(1, 2, 1, 1);
        put_alu(2, 3, 1, 2);
        put_alu(3, 1, 3, 0);
        put_alu(4, 4, 1, 2);
        put_alu(5, 7, 0, 0);
        put_alu(6, 7, 0, 0);
        put_alu(7, 8, 7, 7);
        put_alu(8, 0, 1, 1);
        put_alu(9, 9, 0, 0);
        n_prog = 10;
        for (int i = 0; i < 10; i++) exp_path[i] = i;
        run_prog("straight", 10, 0, 0, 13);
    endtask

    // R3, R4: one not-taken branch, consumer after the bubble.
    task automatic t_not_taken();
        clear_prog();
        put_alu(0, 1, 0, 0);
        put_br(1, 1, 1'b0, 0);
        put_alu(2, 2, 1, 1);
        n_prog = 3;
        exp_path[0] = 0; exp_path[1] = 1; exp_path[2] = 2;
        run_prog("not_taken", 3, 1, 0, 7);
    endtask

    // R5, R9: taken branch skips an instruction that must never retire.
    task automatic t_taken();
        clear_prog();
        put_alu(0, 1, 0, 0);
        put_br(1, 1, 1'b1, 3);
        put_alu(2, 5, 0, 0);
        put_alu(3, 2, 1, 5);
        n_prog = 4;
        exp_path[0] = 0; exp_path[1] = 1; exp_path[2] = 3;
        run_prog("taken", 3, 1, 1, 8);
    endtask

    // R3, R4, R5: back-to-back branches of both outcomes.
    task automatic t_mixed();
        clear_prog();
        put_br(0, 0, 1'b0, 0);
        put_br(1, 0, 1'b1, 4);
        put_alu(2, 6, 0, 0);
        put_alu(3, 6, 0, 0);
        put_alu(4, 1, 0, 0);
        put_br(5, 1, 1'b1, 7);
        put_alu(6, 1, 0, 0);
        put_alu(7, 2, 1, 1);
        n_prog = 8;
        exp_path[0] = 0; exp_path[1] = 1; exp_path[2] = 4;
        exp_path[3] = 5; exp_path[4] = 7;
        run_prog("mixed", 5, 3, 2, 13);
    endtask

    initial begin
        t_reset();
        t_straight();
        t_not_taken();
        t_taken();
        t_mixed();
        all_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!all_done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule